// File: doc/BRIEF.md
# Three-Phase Complementary PWM Output Stage

This block produces six PWM pins from three duty channels (A, B, C) that share one free-running period counter. Each channel drives a true pin, which is high while the counter is below that channel's active duty, and an inverted pin that carries the opposite phase. A control register gives every pin its own enable bit. It also has a mode bit that blanks all six pins when set, because the alternate drive modes are not implemented.

Software programs the block through a plain write port (address, data, strobe). Duty writes never change a waveform in the middle of a period. They are staged and applied at the next period boundary. With the update-all flag set, writes to the B and C duties are parked in hold registers. The next write to the A duty then commits all three together, so the three phases change at the same boundary.

Top module: `pwm3_stage`

## Requirements
- R1: The counter runs 0,1,..,P and returns to 0 on the clock edge after it equals the period P (address 0, reset value 0). The period seen on the pins is therefore P+1 cycles.
- R2: A channel's true pin is high exactly while the counter is less than its active duty. A duty of 0 keeps it low, and a duty above P keeps it high.
- R3: Whenever both pins of a channel are enabled, the inverted pin is the exact complement of the true pin.
- R4: Pin-control register (address 4), bits 5..0 enable pwm_o[5..0] = A-true, A-inverted, B-true, B-inverted, C-true, C-inverted. A pin whose bit is 0 is held at 0.
- R5: Pin-control bit 7 set forces all six pins to 0. Bit 6 has no effect.
- R6: With update-all clear (address 5, bit 0), a write to duty A, B or C (addresses 1, 2, 3) changes only that channel's pair. It takes effect on the period boundary, which is the edge where the counter returns to 0.
- R7: With update-all set, B and C writes do not alter the pins. A later A write commits the held B and C values together with the new A value, and all three take effect at the same next boundary.
- R8: A duty write made in the same cycle as a boundary takes effect at the following boundary. The last value written before a boundary wins.
- R9: After reset all registers are zero and every pin is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Write data |
| pwm_o | output | 6 | Pins: [5] A-true, [4] A-inv, [3] B-true, [2] B-inv, [1] C-true, [0] C-inv |

## Verification
The bench builds the block with DW = 8 and uses short periods (0, 3, 9). Each boundary therefore arrives within a few cycles, and many boundaries occur in one short run. This brings within reach the corner cases: duty 0, duty above the period, a period of 0 (wrap on every cycle) and writes landing on every possible counter phase, including the boundary cycle itself.

// File: rtl/pwm3_stage.sv
module pwm3_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [5:0]    pwm_o
);
  localparam int NCH = 3;

  logic [DW-1:0] cnt, per;
  logic [7:0]    ctrl;
  logic          upd_all;
  logic [DW-1:0] act  [NCH];
  logic [DW-1:0] pend [NCH];
  logic [DW-1:0] hold [NCH];
  logic [NCH-1:0] pend_v;
  logic          wrap;
  logic [NCH-1:0] lt;

  assign wrap = (cnt >= per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per     <= '0;
      ctrl    <= '0;
      upd_all <= 1'b0;
      pend_v  <= '0;
      for (int i = 0; i < NCH; i++) begin
        act[i]  <= '0;
        pend[i] <= '0;
        hold[i] <= '0;
      end
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        for (int i = 0; i < NCH; i++)
          if (pend_v[i]) act[i] <= pend[i];
        pend_v <= '0;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: per <= wr_data;
          3'd1: begin
            pend[0]   <= wr_data;
            pend_v[0] <= 1'b1;
            if (upd_all) begin
              for (int i = 1; i < NCH; i++) begin
                pend[i]   <= hold[i];
                pend_v[i] <= 1'b1;
              end
            end
          end
          3'd2, 3'd3: begin
            hold[wr_addr-3'd1] <= wr_data;
            if (!upd_all) begin
              pend[wr_addr-3'd1]   <= wr_data;
              pend_v[wr_addr-3'd1] <= 1'b1;
            end
          end
          3'd4: ctrl    <= wr_data[7:0];
          3'd5: upd_all <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign lt[g] = (cnt < act[g]);
  end

  assign pwm_o = ctrl[7] ? 6'b0
               : ({lt[0], ~lt[0], lt[1], ~lt[1], lt[2], ~lt[2]} & ctrl[5:0]);
endmodule

// File: rtl/pwm3_stage_chk.sv
module pwm3_stage_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] per,
  input logic [7:0]    ctrl,
  input logic [DW-1:0] act_a,
  input logic          wrap,
  input logic [5:0]    pwm_o
);
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == per) |=> (cnt == '0));

  assert_duty_zero_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a == '0) |-> !pwm_o[5]);

  assert_pair_opposite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && ctrl[5] && ctrl[4]) |-> (pwm_o[5] != pwm_o[4]));

  assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_o & ~ctrl[5:0]) == 6'b0));

  assert_force_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |-> (pwm_o == 6'b0));

  assert_mid_period_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_a));
endmodule

bind pwm3_stage pwm3_stage_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .per(per), .ctrl(ctrl),
  .act_a(act[0]), .wrap(wrap), .pwm_o(pwm_o)
);

// File: tb/sim_pwm3_stage.sv
module sim_pwm3_stage;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [5:0] pwm_o;

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R9";
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_per, m_ctrl, m_ua;
  int m_act[3], m_pend[3], m_hold[3];
  bit m_pv[3];

  pwm3_stage #(.DW(DW)) u0 (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_ctrl = 0; m_ua = 0;
      for (int i = 0; i < 3; i++) begin m_act[i] = 0; m_pend[i] = 0; m_hold[i] = 0; m_pv[i] = 0; end
    end else begin
      int ua_old;
      ua_old = m_ua;
      if (m_cnt >= m_per) begin
        m_cnt = 0;
        for (int i = 0; i < 3; i++) begin
          if (m_pv[i]) m_act[i] = m_pend[i];
          m_pv[i] = 0;
        end
      end else m_cnt = m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          0: m_per = wr_data;
          1: begin
            m_pend[0] = wr_data; m_pv[0] = 1;
            if (ua_old != 0)
              for (int i = 1; i < 3; i++) begin m_pend[i] = m_hold[i]; m_pv[i] = 1; end
          end
          2, 3: begin
            m_hold[wr_addr-1] = wr_data;
            if (ua_old == 0) begin m_pend[wr_addr-1] = wr_data; m_pv[wr_addr-1] = 1; end
          end
          4: m_ctrl = wr_data;
          5: m_ua = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [5:0] expect_pins();
    logic [5:0] raw;
    if (m_ctrl[7]) return 6'b0;
    for (int c = 0; c < 3; c++) begin
      raw[5-2*c] = (m_cnt < m_act[c]);
      raw[4-2*c] = !(m_cnt < m_act[c]);
    end
    return raw & m_ctrl[5:0];
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [5:0] e;
      e = expect_pins();
      checks++;
      if (pwm_o !== e) begin
        fails++;
        $display("FAIL %s (R2/R3/R4 pin compare) cyc=%0d pwm_o=%b expected=%b", phase, cyc, pwm_o, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R9: reset state at the pins
    checks++;
    if (pwm_o !== 6'b0) begin fails++; $display("FAIL R9 pwm_o=%b expected=000000", pwm_o); end
    rst_n = 1;
    idle(4);

    phase = "R1";
    wr(0, 9);
    phase = "R2";
    wr(4, 8'h3F);
    wr(1, 3); wr(2, 5); wr(3, 0);
    idle(30);
    phase = "R2";
    wr(3, 12);
    idle(25);
    phase = "R4";
    wr(4, 8'h2A); idle(22);
    wr(4, 8'h15); idle(22);
    phase = "R5";
    wr(4, 8'h7F); idle(22);
    wr(4, 8'hBF); idle(22);
    wr(4, 8'h3F);
    phase = "R6";
    wr(2, 8); idle(25);
    phase = "R7";
    wr(5, 1);
    wr(2, 2); wr(3, 7); idle(25);
    wr(1, 6); idle(25);
    wr(5, 0);
    phase = "R8";
    for (int k = 0; k < 12; k++) begin
      wr(1, k);
      idle(k + 1);
    end
    wr(1, 4); wr(1, 7); idle(20);
    phase = "R1";
    wr(0, 3); idle(16);
    wr(0, 0); idle(8);
    wr(0, 9); idle(22);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule